// File: doc/BRIEF.md
# Interrupt Source Conditioning and Masking Unit

This block takes a parameterised set of asynchronous interrupt lines and turns each into a clean, maskable request. Every line is first brought into the clock domain by a two-stage synchroniser. Each line then passes through its own programmable detector. The detector either follows the line as a level, with a selectable active sense, or records transitions in a sticky latch. It can record rising edges, falling edges, or both.

Software reaches the unit over a simple 32-bit register bus. The bus carries a word address, a write strobe and a read strobe. Read data comes back registered, one cycle after the read strobe. Interrupt configuration is packed 32 interrupts to a word. The enable mask has no plain read/write register. It changes only through a write-one-to-enable port and a write-one-to-disable port. A separate command word lets software force one edge latch on or off, naming the interrupt in its low byte.

The outputs are a per-interrupt request vector and a single summary request. Each request is the pending state gated by its enable. The register bus is a control path, so it uses plain strobes and has no back-pressure. Every access completes in the cycle its strobe is sampled.

Top module: `irq_condition_unit`

## Requirements
- R1: After reset, all polarity, trigger and dual-edge bits, all enables and all edge latches are 0, and `irq_req` and `irq_any` are 0.
- R2: An input change applied between clock edges shows in the level-mode pending state after the second rising edge that follows it, and not after the first.
- R3: In level mode (trigger bit 0), an interrupt is pending while its synchronised input equals its polarity bit: polarity 1 means active-high and polarity 0 means active-low.
- R4: In edge mode (trigger bit 1) with dual-edge 0, a rising transition sets the edge latch when polarity is 1, and a falling transition sets it when polarity is 0. The latch stays set, and the interrupt stays pending, until software clears it.
- R5: In edge mode with the dual-edge bit set, both rising and falling transitions set the latch, whatever the polarity bit is.
- R6: A write to the edge-command word (byte 0x280) sets the latch of interrupt `wdata[7:0]` when `wdata[31]`=1 and clears it when `wdata[31]`=0. Numbers at or above NUM_IRQ have no effect. A hardware edge recorded in the same cycle as a clear command wins, and the latch ends up set.
- R7: A write to the enable-set bank (byte 0x380) enables each interrupt whose data bit is 1. A write to the enable-clear bank (byte 0x300) disables each interrupt whose data bit is 1. Data bits that are 0 leave their enables unchanged.
- R8: `irq_req[n]` = pending[n] AND enable[n], and `irq_any` is the OR of all bits of `irq_req`.
- R9: The word address is the byte offset divided by 4. Interrupt n lies in word n/32 of a bank, at bit n%32. The banks start at these byte offsets: polarity 0x100, trigger 0x180, dual-edge 0x200, enable readback 0x400 (1 = enabled), pending readback 0x480. Each of these reads back its current state.
- R10: Reads of the command word, the enable-set bank, the enable-clear bank, unmapped offsets, and bank words beyond the last implemented interrupt all return 0. Writes to the enable-readback and pending banks are ignored.
- R11: `bus_rdata` is loaded on the rising edge where `bus_rd` is 1, with the state held before that edge. It holds its value when no read is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_IRQ | Raw asynchronous interrupt lines |
| bus_addr | input | 10 | Word address (byte offset / 4) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq_req | output | NUM_IRQ | Per-interrupt masked request |
| irq_any | output | 1 | OR of all requests |

## Verification
The bench targets the exact two-edge synchroniser delay; an extra or a missing stage shifts every request by one cycle against the model. It forces a clear command into the same cycle as a detected edge, which a design that gave the clear priority would lose. It pulses lines with polarity set against the transition in single- and dual-edge modes, where a design that ignored polarity or dual-edge would latch, or miss, the event. It also writes zero bits to the set and clear banks, writes to read-only banks and reads write-only or out-of-range words. Any of these would corrupt the enables or leak stale data onto the read bus.

// File: rtl/irq_cond_pkg.sv
package irq_cond_pkg;

  localparam int ADDR_W    = 10;
  localparam int DATA_W    = 32;
  localparam int CMD_IDX_W = 8;
  localparam int CMD_SET_B = 31;

  // Bank order matters: bank index = (word address - 0x40) / 32
  typedef enum logic [2:0] {
    BK_POL   = 3'd0,
    BK_TRIG  = 3'd1,
    BK_DUAL  = 3'd2,
    BK_CMD   = 3'd3,
    BK_CLR   = 3'd4,
    BK_SET   = 3'd5,
    BK_MASK  = 3'd6,
    BK_PEND  = 3'd7
  } bank_e;

  typedef struct packed {
    logic       hit;
    bank_e      bank;
    logic [2:0] word;
  } dec_t;

  function automatic dec_t decode_addr(input logic [ADDR_W-1:0] a);
    dec_t             d;
    logic [ADDR_W-1:0] rel;
    rel    = a - 10'h040;
    d.hit  = (a >= 10'h040) && (rel[9:8] == 2'b00) && (rel[4:3] == 2'b00);
    d.bank = bank_e'(rel[7:5]);
    d.word = rel[2:0];
    return d;
  endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH  = 64,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_detect.sv
module irq_detect #(
  parameter int NUM_IRQ = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] sync_i,
  input  logic [NUM_IRQ-1:0] pol_i,
  input  logic [NUM_IRQ-1:0] trig_i,
  input  logic [NUM_IRQ-1:0] dual_i,
  input  logic [NUM_IRQ-1:0] cmd_set_i,
  input  logic [NUM_IRQ-1:0] cmd_clr_i,
  output logic [NUM_IRQ-1:0] pend_o
);
  logic [NUM_IRQ-1:0] prev_q;
  logic [NUM_IRQ-1:0] latch_q;
  logic [NUM_IRQ-1:0] evt;
  logic               live_q;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    logic rise, fall, lvl;
    assign rise   = sync_i[i] & ~prev_q[i];
    assign fall   = ~sync_i[i] & prev_q[i];
    assign evt[i] = trig_i[i] & (dual_i[i] ? (rise | fall)
                                           : (pol_i[i] ? rise : fall));
    assign lvl    = pol_i[i] ? sync_i[i] : ~sync_i[i];
    assign pend_o[i] = trig_i[i] ? latch_q[i] : lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      latch_q <= '0;
      live_q  <= 1'b0;
    end else begin
      prev_q  <= sync_i;
      // a recorded edge or set command wins over a clear command
      latch_q <= (latch_q & ~cmd_clr_i) | evt | cmd_set_i;
      live_q  <= 1'b1;
    end
  end

  assert_latch_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> ((($past(latch_q) & ~$past(cmd_clr_i)) & ~latch_q) == '0));

  assert_edge_records_R4: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> (($past(evt) & ~latch_q) == '0));

  assert_cmd_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> (($past(cmd_clr_i & ~evt & ~cmd_set_i) & latch_q) == '0));

  assert_cmd_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> (($past(cmd_set_i) & ~latch_q) == '0));
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_cond_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic               bus_rd,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_IRQ-1:0] pend_i,
  output logic [NUM_IRQ-1:0] pol_o,
  output logic [NUM_IRQ-1:0] trig_o,
  output logic [NUM_IRQ-1:0] dual_o,
  output logic [NUM_IRQ-1:0] en_o,
  output logic [NUM_IRQ-1:0] cmd_set_o,
  output logic [NUM_IRQ-1:0] cmd_clr_o
);
  localparam int NUM_WORDS = (NUM_IRQ + DATA_W - 1) / DATA_W;
  localparam int PADW      = NUM_WORDS * DATA_W;
  localparam logic [PADW-1:0] VALID = {PADW{1'b1}} >> (PADW - NUM_IRQ);
  localparam int NUM_CFG   = 3;

  dec_t              dec;
  logic              word_ok;
  logic [PADW-1:0]   wvec, word_mask;
  logic [PADW-1:0]   cfg_q [NUM_CFG];
  logic [PADW-1:0]   en_q;
  logic [PADW-1:0]   set_vec, clr_vec;
  logic              cmd_hit;
  logic [CMD_IDX_W-1:0] cmd_idx;
  logic [NUM_IRQ-1:0]   cmd_onehot;
  logic [PADW-1:0]   rd_src, pend_pad;
  logic              rd_map;
  logic [DATA_W-1:0] rdata_q;
  logic              live_q;

  assign dec       = decode_addr(bus_addr);
  assign word_ok   = dec.hit && (32'(dec.word) < 32'(NUM_WORDS));
  assign wvec      = {NUM_WORDS{bus_wdata}};
  assign word_mask = word_ok ? ((PADW'(32'hFFFF_FFFF) << (DATA_W * dec.word)) & VALID)
                             : '0;

  // configuration banks share one write path, indexed by bank code
  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q[g] <= '0;
      else if (bus_wr && dec.bank == bank_e'(g))
        cfg_q[g] <= (cfg_q[g] & ~word_mask) | (wvec & word_mask);
    end
  end

  assign set_vec = (bus_wr && dec.bank == BK_SET) ? (wvec & word_mask) : '0;
  assign clr_vec = (bus_wr && dec.bank == BK_CLR) ? (wvec & word_mask) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= (en_q | set_vec) & ~clr_vec;
  end

  assign cmd_hit    = bus_wr && dec.hit && (dec.bank == BK_CMD) && (dec.word == 3'd0);
  assign cmd_idx    = bus_wdata[CMD_IDX_W-1:0];
  assign cmd_onehot = (cmd_hit && (32'(cmd_idx) < 32'(NUM_IRQ)))
                      ? ({{(NUM_IRQ-1){1'b0}}, 1'b1} << cmd_idx) : '0;
  assign cmd_set_o  = bus_wdata[CMD_SET_B] ? cmd_onehot : '0;
  assign cmd_clr_o  = bus_wdata[CMD_SET_B] ? '0 : cmd_onehot;

  assign pend_pad = PADW'(pend_i);

  always_comb begin
    rd_map = word_ok;
    unique case (dec.bank)
      BK_POL:  rd_src = cfg_q[0];
      BK_TRIG: rd_src = cfg_q[1];
      BK_DUAL: rd_src = cfg_q[2];
      BK_MASK: rd_src = en_q;
      BK_PEND: rd_src = pend_pad;
      default: begin rd_src = '0; rd_map = 1'b0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      live_q  <= 1'b0;
    end else begin
      live_q <= 1'b1;
      if (bus_rd)
        rdata_q <= rd_map ? DATA_W'(rd_src >> (DATA_W * dec.word)) : '0;
    end
  end

  assign bus_rdata = rdata_q;
  assign pol_o  = cfg_q[0][NUM_IRQ-1:0];
  assign trig_o = cfg_q[1][NUM_IRQ-1:0];
  assign dual_o = cfg_q[2][NUM_IRQ-1:0];
  assign en_o   = en_q[NUM_IRQ-1:0];

  assert_set_enables_R7: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> (($past(set_vec) & ~en_q) == '0));

  assert_clr_disables_R7: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> (($past(clr_vec) & en_q) == '0));

  assert_zero_bits_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> (((en_q ^ $past(en_q)) & ~$past(set_vec | clr_vec)) == '0));

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !rd_map) |=> (bus_rdata == '0));

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && !bus_rd) |=> $stable(bus_rdata));
endmodule

// File: rtl/irq_condition_unit.sv
module irq_condition_unit
  import irq_cond_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic               bus_rd,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic [NUM_IRQ-1:0] irq_req,
  output logic               irq_any
);
  logic [NUM_IRQ-1:0] sync_w, pend_w, pol_w, trig_w, dual_w, en_w, cset_w, cclr_w;

  irq_sync #(.WIDTH(NUM_IRQ), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(irq_in), .q_o(sync_w));

  irq_regs #(.NUM_IRQ(NUM_IRQ)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pend_i(pend_w), .pol_o(pol_w), .trig_o(trig_w), .dual_o(dual_w),
    .en_o(en_w), .cmd_set_o(cset_w), .cmd_clr_o(cclr_w));

  irq_detect #(.NUM_IRQ(NUM_IRQ)) u_detect (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_w), .pol_i(pol_w),
    .trig_i(trig_w), .dual_i(dual_w), .cmd_set_i(cset_w),
    .cmd_clr_i(cclr_w), .pend_o(pend_w));

  assign irq_req = pend_w & en_w;
  assign irq_any = |irq_req;

  assert_req_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req & ~en_w) == '0);

  assert_any_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any |-> (irq_req != '0));
endmodule

// File: tb/test_irq_condition_unit.sv
`timescale 1ns/1ps
module test_irq_condition_unit;
  localparam int N = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_in = '0;
  logic [9:0]    bus_addr = '0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  irq_req;
  logic          irq_any;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_condition_unit #(.NUM_IRQ(N)) i_irq_condition_unit (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .irq_req(irq_req), .irq_any(irq_any));

  // behavioural reference model
  logic [N-1:0] m_pol, m_trig, m_dual, m_en, m_latch, m_s1, m_s2, m_prev;
  logic [31:0]  m_rdata;

  function automatic logic [N-1:0] m_pending();
    logic [N-1:0] p;
    for (int i = 0; i < N; i++)
      p[i] = m_trig[i] ? m_latch[i] : (m_s2[i] == m_pol[i]);
    return p;
  endfunction

  function automatic logic [31:0] m_read(input logic [9:0] a);
    int bank, w;
    logic [N-1:0] src;
    if (a < 10'h040 || a >= 10'h140) return 32'd0;
    bank = (int'(a) - 64) / 32;
    w    = (int'(a) - 64) % 32;
    if (w > 1) return 32'd0;
    case (bank)
      0: src = m_pol;
      1: src = m_trig;
      2: src = m_dual;
      6: src = m_en;
      7: src = m_pending();
      default: return 32'd0;
    endcase
    return src[w*32 +: 32];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pol = '0; m_trig = '0; m_dual = '0; m_en = '0; m_latch = '0;
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_rdata = '0;
    end else begin
      if (bus_rd) m_rdata = m_read(bus_addr);
      for (int i = 0; i < N; i++) begin
        bit rise, fall, ev, cs, cc;
        rise = m_s2[i] && !m_prev[i];
        fall = !m_s2[i] && m_prev[i];
        ev   = m_trig[i] && (m_dual[i] ? (rise || fall) : (m_pol[i] ? rise : fall));
        cs   = bus_wr && bus_addr == 10'h0A0 && bus_wdata[7:0] == 8'(i) && bus_wdata[31];
        cc   = bus_wr && bus_addr == 10'h0A0 && bus_wdata[7:0] == 8'(i) && !bus_wdata[31];
        if (ev || cs) m_latch[i] = 1'b1;
        else if (cc) m_latch[i] = 1'b0;
      end
      if (bus_wr && bus_addr >= 10'h040 && bus_addr < 10'h140) begin
        int bank, w;
        bank = (int'(bus_addr) - 64) / 32;
        w    = (int'(bus_addr) - 64) % 32;
        if (w <= 1) begin
          case (bank)
            0: m_pol[w*32 +: 32]  = bus_wdata;
            1: m_trig[w*32 +: 32] = bus_wdata;
            2: m_dual[w*32 +: 32] = bus_wdata;
            4: m_en[w*32 +: 32]   = m_en[w*32 +: 32] & ~bus_wdata;
            5: m_en[w*32 +: 32]   = m_en[w*32 +: 32] | bus_wdata;
            default: ;
          endcase
        end
      end
      m_prev = m_s2; m_s2 = m_s1; m_s1 = irq_in;
    end
  end

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R8 irq_req vs model", 64'(irq_req), 64'(m_pending() & m_en));
      chk("R8 irq_any vs model", 64'(irq_any), 64'(|(m_pending() & m_en)));
      chk("R11 bus_rdata vs model", 64'(bus_rdata), 64'(m_rdata));
    end
  end

  task automatic do_write(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_read(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq_req after reset", 64'(irq_req), 64'd0);
    chk("R1 irq_any after reset", 64'(irq_any), 64'd0);
    do_read(10'h040, rd); chk("R1 polarity reset", 64'(rd), 64'd0);
    do_read(10'h060, rd); chk("R1 trigger reset", 64'(rd), 64'd0);
    do_read(10'h080, rd); chk("R1 dual reset", 64'(rd), 64'd0);
    do_read(10'h100, rd); chk("R1 enable reset", 64'(rd), 64'd0);

    // R7 write-one set / clear semantics
    do_write(10'h0E0, 32'h0000_00FF);
    do_read(10'h100, rd); chk("R7 set enables", 64'(rd), 64'h0000_00FF);
    do_write(10'h0C0, 32'h0000_000F);
    do_read(10'h100, rd); chk("R7 clear enables", 64'(rd), 64'h0000_00F0);
    do_write(10'h0E0, 32'h0);
    do_read(10'h100, rd); chk("R7 zero bits no effect", 64'(rd), 64'h0000_00F0);

    // R10 read-only ignored, write-only and unmapped read zero
    do_write(10'h100, 32'hFFFF_FFFF);
    do_read(10'h100, rd); chk("R10 write to enable readback ignored", 64'(rd), 64'h0000_00F0);
    do_read(10'h0E0, rd); chk("R10 set bank reads zero", 64'(rd), 64'd0);
    do_read(10'h0C0, rd); chk("R10 clear bank reads zero", 64'(rd), 64'd0);
    do_read(10'h0A0, rd); chk("R10 command reads zero", 64'(rd), 64'd0);
    do_read(10'h000, rd); chk("R10 unmapped reads zero", 64'(rd), 64'd0);
    do_read(10'h122, rd); chk("R10 word beyond last irq reads zero", 64'(rd), 64'd0);

    // R3 polarity in level mode
    do_read(10'h120, rd); chk("R3 active-low pending", 64'(rd), 64'hFFFF_FFFF);
    do_write(10'h040, 32'h0000_00F0);
    do_read(10'h120, rd); chk("R3 active-high pending", 64'(rd), 64'hFFFF_FF0F);
    chk("R8 masked requests zero", 64'(irq_req), 64'd0);
    chk("R8 summary zero", 64'(irq_any), 64'd0);

    // R2 two-edge synchroniser delay
    @(negedge clk); irq_in[5] = 1'b1;
    @(negedge clk); chk("R2 not after first edge", 64'(irq_req[5]), 64'd0);
    @(negedge clk); chk("R2 after second edge", 64'(irq_req[5]), 64'd1);
    chk("R8 summary follows request", 64'(irq_any), 64'd1);
    irq_in[5] = 1'b0;
    wait_cyc(3);

    // R4 single-edge sticky latch
    do_write(10'h040, 32'h0000_01F0);
    do_write(10'h060, 32'h0000_0700);
    do_write(10'h0E0, 32'h0000_0700);
    @(negedge clk); irq_in[8] = 1'b1;
    @(negedge clk); irq_in[8] = 1'b0;
    wait_cyc(4); chk("R4 rising edge latched and sticky", 64'(irq_req[8]), 64'd1);
    do_write(10'h0A0, 32'h0000_0008);
    chk("R6 clear command", 64'(irq_req[8]), 64'd0);
    irq_in[9] = 1'b1;
    wait_cyc(4); chk("R4 rising ignored with polarity 0", 64'(irq_req[9]), 64'd0);
    irq_in[9] = 1'b0;
    wait_cyc(4); chk("R4 falling latched with polarity 0", 64'(irq_req[9]), 64'd1);

    // R5 dual-edge ignores polarity
    do_write(10'h080, 32'h0000_0400);
    irq_in[10] = 1'b1;
    wait_cyc(4); chk("R5 dual rising", 64'(irq_req[10]), 64'd1);
    do_write(10'h0A0, 32'h0000_000A);
    chk("R5 cleared", 64'(irq_req[10]), 64'd0);
    irq_in[10] = 1'b0;
    wait_cyc(4); chk("R5 dual falling", 64'(irq_req[10]), 64'd1);

    // R6 command set / clear / out of range / edge wins
    do_write(10'h0A0, 32'h0000_0009);
    chk("R6 clear irq 9", 64'(irq_req[9]), 64'd0);
    do_write(10'h0A0, 32'h8000_0009);
    chk("R6 set irq 9", 64'(irq_req[9]), 64'd1);
    do_write(10'h0A0, 32'h8000_0048);
    chk("R6 out-of-range number ignored", 64'(irq_req), 64'h0000_0000_0000_0600);
    @(negedge clk); irq_in[8] = 1'b1;
    @(negedge clk);
    do_write(10'h0A0, 32'h0000_0008);
    chk("R6 edge wins over clear", 64'(irq_req[8]), 64'd1);
    irq_in[8] = 1'b0;

    // R9 packing across words
    do_write(10'h081, 32'hA5A5_0000);
    do_read(10'h081, rd); chk("R9 dual word 1 readback", 64'(rd), 64'hA5A5_0000);
    do_write(10'h041, 32'h0000_0100);
    do_read(10'h121, rd); chk("R9 irq 40 at word 1 bit 8", 64'(rd), 64'hFFFF_FEFF);

    // randomised traffic, checked against the model every clock
    for (int k = 0; k < 3000; k++) begin
      int op;
      @(negedge clk);
      irq_in = {$urandom, $urandom};
      bus_wr = 1'b0; bus_rd = 1'b0;
      op = $urandom_range(0, 9);
      if (op < 6) begin
        logic [9:0] bases [7] = '{10'h040, 10'h060, 10'h080, 10'h0A0, 10'h0C0, 10'h0E0, 10'h100};
        bus_addr  = bases[$urandom_range(0, 6)] + 10'($urandom_range(0, 2));
        bus_wdata = {$urandom};
        if (bus_addr[7:0] == 8'hA0) bus_wdata[7:0] = 8'($urandom_range(0, 80));
        bus_wr = 1'b1;
      end else begin
        bus_addr = 10'($urandom_range(0, 330));
        bus_rd   = 1'b1;
      end
    end
    @(negedge clk); bus_wr = 1'b0; bus_rd = 1'b0;
    wait_cyc(4);
    finish_run();
  end
endmodule